// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block protects a multiplexed address/data bus and its command/byte-enable lanes with a single even-parity line. Each cycle a phase is in progress, the block folds the address/data and command/byte-enable values into one parity bit. When the local agent is the source of that phase, the bit goes out on the parity line one clock later. When another agent is the source, the block compares the parity bit received one clock later against the bit it computed itself.

A mismatch on a received data phase is flagged on an active-low data-error output. A mismatch on a received address phase is treated as serious and raises a one-clock pull-down request on an open-drain system-error line. Each output has its own configuration enable. A sticky flag records every received mismatch, even when reporting is turned off, and stays set until software writes a one to clear it.

The surrounding bus interface supplies the phase strobes and the direction bit. Tri-state drivers and any interrupt built from the error outputs sit outside this block.

Top module: `busparity_unit`

## Requirements
- R1: In the cycle after a locally sourced phase, `par_out` is set so that `ad`, `cbe` of that phase plus `par_out` hold an even number of ones, i.e. `par_out` = XOR of all 36 bits.
- R2: `par_oe` is 1 in exactly the cycle after a cycle with `addr_phase` or `data_phase` high and `local_drv` = 1, and 0 in every other cycle.
- R3: With `perr_en` = 1, a received data phase (`data_phase` = 1, `local_drv` = 0) whose `par_in` one cycle later breaks even parity drives `perr_n` low in the second cycle after that phase, for one cycle.
- R4: With `perr_en` = 0 in the parity cycle, a received data-phase mismatch leaves `perr_n` high.
- R5: With `serr_en` = 1, a received address phase whose `par_in` one cycle later breaks even parity drives `serr_low` to 1 for one cycle, in the second cycle after the phase. `perr_n` stays high.
- R6: With `serr_en` = 0, a received address-phase mismatch leaves `serr_low` at 0.
- R7: A locally sourced phase never raises `perr_n` low, `serr_low` or the sticky flag, whatever `par_in` carries.
- R8: When neither strobe is high, `par_in` in the following cycle has no effect on `perr_n`, `serr_low` or the sticky flag.
- R9: `par_err_seen` becomes 1 in the second cycle after any received phase with a mismatch, even when both enables are 0. It holds until a cycle with `stat_clr` = 1 and reads 0 after it.
- R10: When a new mismatch and `stat_clr` reach the same clock edge, `par_err_seen` stays 1.
- R11: When `addr_phase` and `data_phase` are both high, the phase counts as an address phase, so an error goes to `serr_low` and not to `perr_n`.
- R12: After reset, `par_oe` = 0, `perr_n` = 1, `serr_low` = 0 and `par_err_seen` = 0.
- R13: Received phases with correct parity, back to back or isolated, raise no error output and leave the sticky flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| ad | input | 32 | Address/data value of the current phase |
| cbe | input | 4 | Command/byte-enable value of the current phase |
| addr_phase | input | 1 | An address phase is in progress this cycle |
| data_phase | input | 1 | A data phase completes this cycle |
| local_drv | input | 1 | 1 when the local agent sources the current phase |
| par_in | input | 1 | Parity line as seen on the bus |
| perr_en | input | 1 | Enables data-phase error reporting |
| serr_en | input | 1 | Enables address-phase error reporting |
| stat_clr | input | 1 | Write-one-to-clear pulse for the sticky flag |
| par_out | output | 1 | Parity value to place on the bus |
| par_oe | output | 1 | Output enable for `par_out` |
| perr_n | output | 1 | Active-low data-phase parity error |
| serr_low | output | 1 | Request to pull the open-drain system-error line low |
| par_err_seen | output | 1 | Sticky received-parity-error flag |

## Verification
The block keeps two pieces of state: the parity and phase context held for one cycle, and the registered error flags. If the held parity is wrong, it shows on `par_out` in the very next cycle of a local phase. If the held phase context is wrong (direction or address/data kind), the error lands on the wrong output, or on none, two cycles after the phase. A fault in the sticky flag shows only when it is read after set, hold and clear sequences, which is why those are driven explicitly. The tests cover back-to-back local phases, because a pipeline slip there gives parity that is off by one phase, and the same-edge set/clear case.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

   typedef enum logic [1:0] {
      PH_NONE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_e;

   typedef struct packed {
      phase_e kind;
      logic   local_src;
   } phase_ctx_t;

   localparam phase_ctx_t CTX_IDLE = '{kind: PH_NONE, local_src: 1'b0};

   // Address takes precedence when both strobes are raised together.
   function automatic phase_e classify(input logic is_addr, input logic is_data);
      if (is_addr)      return PH_ADDR;
      else if (is_data) return PH_DATA;
      else              return PH_NONE;
   endfunction

endpackage

// File: rtl/bpar_tree.sv
module bpar_tree #(
   parameter int DW    = 32,
   parameter int CW    = 4,
   parameter int STYLE = 1
) (
   input  logic [DW-1:0] ad,
   input  logic [CW-1:0] cbe,
   output logic          parity
);
   localparam int LW = DW / CW;

   generate
      if (STYLE == 0) begin : g_flat
         assign parity = ^{ad, cbe};
      end else begin : g_lane
         logic [CW-1:0] lane_par;
         for (genvar i = 0; i < CW; i++) begin : g_l
            assign lane_par[i] = (^ad[i*LW +: LW]) ^ cbe[i];
         end
         assign parity = ^lane_par;
      end
   endgenerate

endmodule

// File: rtl/bpar_gen.sv
module bpar_gen
   import bpar_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       calc_par,
   input  logic       addr_phase,
   input  logic       data_phase,
   input  logic       local_drv,
   output logic       par_out,
   output logic       par_oe,
   output logic       exp_par,
   output phase_ctx_t ctx_q
);
   phase_ctx_t ctx_d;
   logic       par_q;

   always_comb begin
      ctx_d.kind      = classify(addr_phase, data_phase);
      ctx_d.local_src = local_drv;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b0;
         ctx_q <= CTX_IDLE;
      end else begin
         par_q <= calc_par;
         ctx_q <= ctx_d;
      end
   end

   assign exp_par = par_q;
   assign par_out = par_q;
   assign par_oe  = (ctx_q.kind != PH_NONE) && ctx_q.local_src;

endmodule

// File: rtl/bpar_chk.sv
module bpar_chk
   import bpar_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       exp_par,
   input  logic       par_in,
   input  phase_ctx_t ctx_q,
   input  logic       perr_en,
   input  logic       serr_en,
   input  logic       stat_clr,
   output logic       perr_n,
   output logic       serr_low,
   output logic       par_err_seen
);
   logic rx_phase, mism, bad_rx;
   logic perr_q, serr_q, seen_q;

   assign rx_phase = (ctx_q.kind != PH_NONE) && !ctx_q.local_src;
   assign mism     = par_in ^ exp_par;
   assign bad_rx   = rx_phase && mism;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perr_q <= 1'b0;
         serr_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         perr_q <= bad_rx && (ctx_q.kind == PH_DATA) && perr_en;
         serr_q <= bad_rx && (ctx_q.kind == PH_ADDR) && serr_en;
         seen_q <= bad_rx || (seen_q && !stat_clr);
      end
   end

   assign perr_n       = ~perr_q;
   assign serr_low     = serr_q;
   assign par_err_seen = seen_q;

endmodule

// File: rtl/busparity_unit.sv
module busparity_unit
   import bpar_pkg::*;
#(
   parameter int DW    = 32,
   parameter int CW    = 4,
   parameter int STYLE = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] ad,
   input  logic [CW-1:0] cbe,
   input  logic          addr_phase,
   input  logic          data_phase,
   input  logic          local_drv,
   input  logic          par_in,
   input  logic          perr_en,
   input  logic          serr_en,
   input  logic          stat_clr,
   output logic          par_out,
   output logic          par_oe,
   output logic          perr_n,
   output logic          serr_low,
   output logic          par_err_seen
);
   generate
      if (DW % CW != 0) begin : g_bad_width
         $error("busparity_unit: DW must be a multiple of CW");
      end
      if (STYLE < 0 || STYLE > 1) begin : g_bad_style
         $error("busparity_unit: STYLE must be 0 or 1");
      end
   endgenerate

   logic       calc_par;
   logic       exp_par;
   phase_ctx_t ctx_q;

   bpar_tree #(.DW(DW), .CW(CW), .STYLE(STYLE)) u_tree (
      .ad     (ad),
      .cbe    (cbe),
      .parity (calc_par)
   );

   bpar_gen u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .calc_par   (calc_par),
      .addr_phase (addr_phase),
      .data_phase (data_phase),
      .local_drv  (local_drv),
      .par_out    (par_out),
      .par_oe     (par_oe),
      .exp_par    (exp_par),
      .ctx_q      (ctx_q)
   );

   bpar_chk u_chk (
      .clk          (clk),
      .rst_n        (rst_n),
      .exp_par      (exp_par),
      .par_in       (par_in),
      .ctx_q        (ctx_q),
      .perr_en      (perr_en),
      .serr_en      (serr_en),
      .stat_clr     (stat_clr),
      .perr_n       (perr_n),
      .serr_low     (serr_low),
      .par_err_seen (par_err_seen)
   );

endmodule

// File: rtl/busparity_unit_props.sv
module busparity_unit_props #(
   parameter int DW = 32,
   parameter int CW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] ad,
   input logic [CW-1:0] cbe,
   input logic          addr_phase,
   input logic          data_phase,
   input logic          local_drv,
   input logic          perr_en,
   input logic          serr_en,
   input logic          stat_clr,
   input logic          par_out,
   input logic          par_oe,
   input logic          perr_n,
   input logic          serr_low,
   input logic          par_err_seen
);
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   logic any_phase;
   assign any_phase = addr_phase | data_phase;

   assert_par_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (any_phase && local_drv) |=> (par_out == $past(^{ad, cbe})));

   assert_oe_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (any_phase && local_drv) |=> par_oe);

   assert_oe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(any_phase && local_drv) |=> !par_oe);

   assert_perr_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && !perr_n) |-> $past(data_phase && !addr_phase && !local_drv, 2));

   assert_perr_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && !perr_n) |-> $past(perr_en));

   assert_serr_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && serr_low) |-> $past(addr_phase && !local_drv, 2));

   assert_serr_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && serr_low) |-> $past(serr_en));

   assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(serr_low && !perr_n));

   assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err_seen && !stat_clr) |=> par_err_seen);

   assert_sticky_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $rose(par_err_seen)) |-> $past(any_phase && !local_drv, 2));

endmodule

bind busparity_unit busparity_unit_props #(.DW(DW), .CW(CW)) u_props (
   .clk          (clk),
   .rst_n        (rst_n),
   .ad           (ad),
   .cbe          (cbe),
   .addr_phase   (addr_phase),
   .data_phase   (data_phase),
   .local_drv    (local_drv),
   .perr_en      (perr_en),
   .serr_en      (serr_en),
   .stat_clr     (stat_clr),
   .par_out      (par_out),
   .par_oe       (par_oe),
   .perr_n       (perr_n),
   .serr_low     (serr_low),
   .par_err_seen (par_err_seen)
);

// File: tb/tb_busparity_unit.sv
`timescale 1ns/1ps
module tb_busparity_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ad = '0;
   logic [3:0]  cbe = '0;
   logic        addr_phase = 1'b0, data_phase = 1'b0, local_drv = 1'b0;
   logic        par_in = 1'b0, perr_en = 1'b1, serr_en = 1'b1, stat_clr = 1'b0;
   logic        par_out, par_oe, perr_n, serr_low, par_err_seen;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   // Snapshots taken by run_phase
   logic s_par, s_oe, s_perr_n, s_serr, s_seen;

   always #2.5 clk = ~clk;

   busparity_unit dut (
      .clk(clk), .rst_n(rst_n), .ad(ad), .cbe(cbe),
      .addr_phase(addr_phase), .data_phase(data_phase), .local_drv(local_drv),
      .par_in(par_in), .perr_en(perr_en), .serr_en(serr_en), .stat_clr(stat_clr),
      .par_out(par_out), .par_oe(par_oe), .perr_n(perr_n),
      .serr_low(serr_low), .par_err_seen(par_err_seen)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive one phase, then parity one cycle later, then snapshot the error cycle.
   task automatic run_phase(input bit is_a, input bit is_d, input bit loc,
                            input logic [31:0] a, input logic [3:0] c,
                            input bit bad, input bit clr_same);
      @(negedge clk);
      addr_phase = is_a; data_phase = is_d; local_drv = loc; ad = a; cbe = c;
      @(negedge clk);
      s_par = par_out; s_oe = par_oe;
      addr_phase = 0; data_phase = 0; local_drv = 0; ad = '0; cbe = '0;
      par_in   = (^{a, c}) ^ bad;
      stat_clr = clr_same;
      @(negedge clk);
      par_in = 0; stat_clr = 0;
      s_perr_n = perr_n; s_serr = serr_low; s_seen = par_err_seen;
   endtask

   task automatic clear_sticky();
      @(negedge clk); stat_clr = 1;
      @(negedge clk); stat_clr = 0;
   endtask

   task automatic t_reset();
      chk("R12 par_oe", par_oe, 0);
      chk("R12 perr_n", perr_n, 1);
      chk("R12 serr_low", serr_low, 0);
      chk("R12 sticky", par_err_seen, 0);
   endtask

   task automatic t_local_burst();
      logic [31:0] words [5];
      logic [3:0]  bes [5];
      words = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'h1234_5678, 32'h0000_0100};
      bes   = '{4'h7, 4'h0, 4'hF, 4'h1, 4'hE};
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i > 0) begin
            chk("R1 burst parity", par_out, ^{words[i-1], bes[i-1]});
            chk("R2 burst oe", par_oe, 1);
         end
         if (i < 5) begin
            data_phase = 1; local_drv = 1; ad = words[i]; cbe = bes[i];
            addr_phase = (i == 0);
         end else begin
            data_phase = 0; addr_phase = 0; local_drv = 0; ad = '0; cbe = '0;
         end
      end
      @(negedge clk);
      chk("R2 oe drops", par_oe, 0);
   endtask

   task automatic t_rx_clean();
      run_phase(1, 0, 0, 32'hDEAD_BEEF, 4'h6, 0, 0);
      chk("R2 no oe on rx", s_oe, 0);
      chk("R13 clean addr serr", s_serr, 0);
      run_phase(0, 1, 0, 32'h0F0F_0F0E, 4'hC, 0, 0);
      chk("R13 clean data perr", s_perr_n, 1);
      chk("R13 clean sticky", s_seen, 0);
   endtask

   task automatic t_rx_data_err();
      perr_en = 1;
      run_phase(0, 1, 0, 32'hA5A5_0001, 4'h3, 1, 0);
      chk("R3 perr low", s_perr_n, 0);
      chk("R3 no serr", s_serr, 0);
      chk("R9 sticky set", s_seen, 1);
      @(negedge clk);
      chk("R3 perr one cycle", perr_n, 1);
      clear_sticky();
      chk("R9 cleared", par_err_seen, 0);
   endtask

   task automatic t_perr_masked();
      perr_en = 0;
      run_phase(0, 1, 0, 32'h0000_00FF, 4'h2, 1, 0);
      chk("R4 perr masked", s_perr_n, 1);
      chk("R9 sticky despite mask", s_seen, 1);
      perr_en = 1;
      clear_sticky();
   endtask

   task automatic t_rx_addr_err();
      serr_en = 1;
      run_phase(1, 0, 0, 32'h4000_0010, 4'h7, 1, 0);
      chk("R5 serr asserted", s_serr, 1);
      chk("R5 perr quiet", s_perr_n, 1);
      @(negedge clk);
      chk("R5 serr one cycle", serr_low, 0);
      clear_sticky();
   endtask

   task automatic t_serr_masked();
      serr_en = 0;
      run_phase(1, 0, 0, 32'h4000_0020, 4'hA, 1, 0);
      chk("R6 serr masked", s_serr, 0);
      chk("R9 sticky with serr masked", s_seen, 1);
      serr_en = 1;
      clear_sticky();
   endtask

   task automatic t_local_ignores();
      run_phase(0, 1, 1, 32'h7777_0000, 4'h9, 1, 0);
      chk("R1 single parity", s_par, ^{32'h7777_0000, 4'h9});
      chk("R7 local data no perr", s_perr_n, 1);
      chk("R7 local sticky", s_seen, 0);
      run_phase(1, 0, 1, 32'h0000_7777, 4'h1, 1, 0);
      chk("R7 local addr no serr", s_serr, 0);
   endtask

   task automatic t_idle_ignored();
      run_phase(0, 0, 0, 32'h1111_1111, 4'h1, 1, 0);
      chk("R8 idle oe", s_oe, 0);
      chk("R8 idle perr", s_perr_n, 1);
      chk("R8 idle serr", s_serr, 0);
      chk("R8 idle sticky", s_seen, 0);
   endtask

   task automatic t_set_wins();
      run_phase(0, 1, 0, 32'hCAFE_0000, 4'h5, 1, 1);
      chk("R10 set beats clear", s_seen, 1);
      clear_sticky();
      chk("R9 clear after hold", par_err_seen, 0);
   endtask

   task automatic t_both_strobes();
      run_phase(1, 1, 0, 32'h0101_0101, 4'h8, 1, 0);
      chk("R11 addr wins serr", s_serr, 1);
      chk("R11 addr wins perr", s_perr_n, 1);
      clear_sticky();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_local_burst();
      t_rx_clean();
      t_rx_data_err();
      t_perr_masked();
      t_rx_addr_err();
      t_serr_masked();
      t_local_ignores();
      t_idle_ignored();
      t_set_wins();
      t_both_strobes();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule